// File: doc/BRIEF.md
# Shadow Write Bridge into a Slow Timekeeping Clock

This block sits between a fast bus clock and a slow (nominally 32 kHz) timekeeping clock. Software writes target words into bus-side shadow copies. The block carries them into the slow domain with a toggle handshake, and each toggle passes through a two-stage synchronizer in each direction. A word that software writes reaches the slow-domain registers only on a slow-clock edge. Software polls a two-bit pending field until it reads zero, and uses that as a fence before it relies on the new value.

Forwarding runs only while the enable bit in the control word is set. The slow domain can also be asked to send its own live state back. A write with bit 31 set to the pending word captures the slow-side live values and copies them into the bus-visible shadow words. Words that still hold an undelivered bus write are left alone. If several writes reach a word before the transfer starts, only the latest value is delivered.

Top module: `shadow_sync_bridge`

## Requirements
- R1: After reset the pending word, the control word, every shadow word and every slow-side register read zero, and `slow_upd` is low.
- R2: A bus write to byte offset 4*i (i below N_WORDS) stores the data in shadow word i, and the data can be read back on the next cycle.
- R3: The control word at offset 0x50 holds the forwarding enable in bit 21. Reading it returns that bit and zero everywhere else.
- R4: While the enable is clear, no transfer starts: the slow-side registers keep their values and pending bit 0 stays set for a word that has been written.
- R5: The pending word at offset 0x68 returns {reload, write} in bits 1:0, and every other bit reads zero. Bit 0 is set from the cycle after a shadow write until the slow domain has acknowledged delivery. Bit 1 is set from a reload request until the reloaded values are in the shadow words.
- R6: The slow-side registers change only on a slow-clock edge that completes a handshake. Each delivery raises `slow_upd` for exactly one slow cycle.
- R7: A delivery changes only the words written since the last transfer started. The other slow-side words keep their values.
- R8: A write that arrives while a transfer is in flight is delivered by a second transfer after it. Several writes to one word before a transfer starts produce a single delivery carrying the last value.
- R9: Writing the pending word with bit 31 set copies `slow_live` into every shadow word through the slow domain. A write with bit 31 clear starts no reload.
- R10: A reload does not overwrite a shadow word whose bus write is still undelivered or in flight.
- R11: Writes to addresses outside the map, or not word-aligned, change nothing, and reads from them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | DW | Write data |
| rd_addr | input | 8 | Byte address of the read |
| rd_data | output | DW | Read data, combinational from rd_addr |
| slow_clk | input | 1 | Slow timekeeping clock |
| slow_rst | input | 1 | Synchronous active-high reset, slow domain |
| slow_live | input | N_WORDS*DW | Live slow-domain state captured on a reload |
| slow_regs | output | N_WORDS*DW | Slow-domain registers fed by delivered writes |
| slow_upd | output | 1 | One-slow-cycle pulse when slow_regs take a delivery |

## Verification
The embedded properties check several rules on every cycle. The enable gates both handshake toggles. The hold buffer stays frozen while a write is in flight. Acknowledges arrive only while a transfer of that kind is outstanding. Slow-side words change only on a handshake pulse, and only for words in the delivery mask. Only the bench scenarios can show end-to-end results: the order and content of deliveries (coalescing while disabled, a second transfer after a write during flight), the reload values seen from the bus, the exclusion of undelivered words from a reload, and the handling of unmapped addresses.

// File: rtl/shsync_pkg.sv
package shsync_pkg;

    localparam int unsigned ADDR_W      = 8;
    localparam logic [7:0]  CTRL_OFFSET = 8'h50;
    localparam logic [7:0]  PEND_OFFSET = 8'h68;
    localparam int unsigned EN_BIT      = 21;
    localparam int unsigned RELOAD_BIT  = 31;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_WORD,
        SEL_CTRL,
        SEL_PEND
    } sel_e;

    typedef struct packed {
        sel_e       sel;
        logic [5:0] idx;
    } dec_t;

    typedef struct packed {
        logic reload;
        logic write;
    } pend_t;

    function automatic dec_t decode_addr(input logic [7:0] a, input int unsigned nw);
        dec_t d;
        d.sel = SEL_NONE;
        d.idx = '0;
        if (a == CTRL_OFFSET) begin
            d.sel = SEL_CTRL;
        end else if (a == PEND_OFFSET) begin
            d.sel = SEL_PEND;
        end else if (a[1:0] == 2'b00 && 32'(a[7:2]) < nw) begin
            d.sel = SEL_WORD;
            d.idx = a[7:2];
        end
        return d;
    endfunction

endpackage

// File: rtl/toggle_rx.sv
module toggle_rx #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tgl_in,
    output logic pulse
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else begin
            sh <= {sh[STAGES-1:0], tgl_in};
        end
    end

    assign pulse = sh[STAGES] ^ sh[STAGES-1];

    // R6: the sender never toggles again before the acknowledge returns
    p_pulse_spaced_r6: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

endmodule

// File: rtl/shsync_bus_side.sv
module shsync_bus_side
    import shsync_pkg::*;
#(
    parameter int unsigned N_WORDS = 4,
    parameter int unsigned DW      = 32,
    parameter int unsigned STAGES  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DW-1:0]           wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [DW-1:0]           rd_data,
    input  logic                    ack_tgl,
    input  logic                    rack_tgl,
    input  logic [N_WORDS*DW-1:0]   cap_flat,
    output logic                    req_tgl,
    output logic                    rreq_tgl,
    output logic [N_WORDS*DW-1:0]   hold_flat,
    output logic [N_WORDS-1:0]      hold_mask
);
    logic [N_WORDS-1:0][DW-1:0] shadow;
    logic [N_WORDS-1:0][DW-1:0] hold;
    logic [N_WORDS-1:0][DW-1:0] cap;
    logic [N_WORDS-1:0]         dirty;
    logic                       enable;
    logic                       wr_busy;
    logic                       rl_req;
    logic                       rl_busy;
    logic                       ack_pulse;
    logic                       rack_pulse;
    logic                       wr_launch;
    logic                       rl_launch;
    dec_t                       wdec;
    dec_t                       rdec;
    pend_t                      pend;

    toggle_rx #(.STAGES(STAGES)) u_ack_rx (
        .clk(clk), .rst(rst), .tgl_in(ack_tgl), .pulse(ack_pulse)
    );
    toggle_rx #(.STAGES(STAGES)) u_rack_rx (
        .clk(clk), .rst(rst), .tgl_in(rack_tgl), .pulse(rack_pulse)
    );

    assign cap       = cap_flat;
    assign hold_flat = hold;
    assign wdec      = decode_addr(wr_addr, N_WORDS);
    assign rdec      = decode_addr(rd_addr, N_WORDS);
    assign wr_launch = enable && !wr_busy && (|dirty);
    assign rl_launch = enable && rl_req && !rl_busy;
    assign pend.write  = wr_busy || (|dirty);
    assign pend.reload = rl_req || rl_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow    <= '0;
            hold      <= '0;
            hold_mask <= '0;
            dirty     <= '0;
            enable    <= 1'b0;
            wr_busy   <= 1'b0;
            rl_req    <= 1'b0;
            rl_busy   <= 1'b0;
            req_tgl   <= 1'b0;
            rreq_tgl  <= 1'b0;
        end else begin
            if (ack_pulse) begin
                wr_busy <= 1'b0;
            end
            if (wr_launch) begin
                hold      <= shadow;
                hold_mask <= dirty;
                dirty     <= '0;
                wr_busy   <= 1'b1;
                req_tgl   <= ~req_tgl;
            end
            if (rl_launch) begin
                rl_req   <= 1'b0;
                rl_busy  <= 1'b1;
                rreq_tgl <= ~rreq_tgl;
            end
            if (rack_pulse) begin
                rl_busy <= 1'b0;
                for (int i = 0; i < N_WORDS; i++) begin
                    if (!dirty[i] && !(wr_busy && hold_mask[i])) begin
                        shadow[i] <= cap[i];
                    end
                end
            end
            if (wr_en) begin
                unique case (wdec.sel)
                    SEL_WORD: begin
                        for (int i = 0; i < N_WORDS; i++) begin
                            if (wdec.idx == 6'(i)) begin
                                shadow[i] <= wr_data;
                                dirty[i]  <= 1'b1;
                            end
                        end
                    end
                    SEL_CTRL: enable <= wr_data[EN_BIT];
                    SEL_PEND: begin
                        if (wr_data[RELOAD_BIT]) begin
                            rl_req <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rdec.sel)
            SEL_WORD: begin
                for (int i = 0; i < N_WORDS; i++) begin
                    if (rdec.idx == 6'(i)) begin
                        rd_data = shadow[i];
                    end
                end
            end
            SEL_CTRL: rd_data[EN_BIT] = enable;
            SEL_PEND: rd_data[1:0] = pend;
            default: ;
        endcase
    end

    p_pend_after_write_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdec.sel == SEL_WORD) |=> pend.write);

    p_no_launch_disabled_r4: assert property (@(posedge clk) disable iff (rst)
        !enable |=> ($stable(req_tgl) && $stable(rreq_tgl)));

    p_hold_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_busy && !ack_pulse) |=> ($stable(hold) && $stable(hold_mask)));

    p_ack_when_busy_r6: assert property (@(posedge clk) disable iff (rst)
        ack_pulse |-> wr_busy);

    p_rack_when_busy_r9: assert property (@(posedge clk) disable iff (rst)
        rack_pulse |-> rl_busy);

endmodule

// File: rtl/shsync_slow_side.sv
module shsync_slow_side #(
    parameter int unsigned N_WORDS = 4,
    parameter int unsigned DW      = 32,
    parameter int unsigned STAGES  = 2
) (
    input  logic                    slow_clk,
    input  logic                    slow_rst,
    input  logic                    req_tgl,
    input  logic                    rreq_tgl,
    input  logic [N_WORDS*DW-1:0]   hold_flat,
    input  logic [N_WORDS-1:0]      hold_mask,
    input  logic [N_WORDS*DW-1:0]   slow_live,
    output logic [N_WORDS*DW-1:0]   slow_regs,
    output logic                    slow_upd,
    output logic                    ack_tgl,
    output logic                    rack_tgl,
    output logic [N_WORDS*DW-1:0]   cap_flat
);
    logic [N_WORDS-1:0][DW-1:0] regs;
    logic [N_WORDS-1:0][DW-1:0] hold;
    logic                       req_pulse;
    logic                       rreq_pulse;

    toggle_rx #(.STAGES(STAGES)) u_req_rx (
        .clk(slow_clk), .rst(slow_rst), .tgl_in(req_tgl), .pulse(req_pulse)
    );
    toggle_rx #(.STAGES(STAGES)) u_rreq_rx (
        .clk(slow_clk), .rst(slow_rst), .tgl_in(rreq_tgl), .pulse(rreq_pulse)
    );

    assign hold      = hold_flat;
    assign slow_regs = regs;

    always_ff @(posedge slow_clk) begin
        if (slow_rst) begin
            regs     <= '0;
            slow_upd <= 1'b0;
            ack_tgl  <= 1'b0;
            rack_tgl <= 1'b0;
            cap_flat <= '0;
        end else begin
            slow_upd <= 1'b0;
            if (req_pulse) begin
                for (int i = 0; i < N_WORDS; i++) begin
                    if (hold_mask[i]) begin
                        regs[i] <= hold[i];
                    end
                end
                slow_upd <= 1'b1;
                ack_tgl  <= ~ack_tgl;
            end
            if (rreq_pulse) begin
                cap_flat <= slow_live;
                rack_tgl <= ~rack_tgl;
            end
        end
    end

    p_regs_on_req_only_r6: assert property (@(posedge slow_clk) disable iff (slow_rst)
        !req_pulse |=> $stable(regs));

    p_upd_one_cycle_r6: assert property (@(posedge slow_clk) disable iff (slow_rst)
        slow_upd |=> !slow_upd);

    for (genvar gi = 0; gi < N_WORDS; gi++) begin : g_word_chk
        p_unmasked_kept_r7: assert property (@(posedge slow_clk) disable iff (slow_rst)
            (req_pulse && !hold_mask[gi]) |=> $stable(regs[gi]));
    end

endmodule

// File: rtl/shadow_sync_bridge.sv
module shadow_sync_bridge
    import shsync_pkg::*;
#(
    parameter int unsigned N_WORDS = 4,
    parameter int unsigned DW      = 32,
    parameter int unsigned STAGES  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DW-1:0]           wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [DW-1:0]           rd_data,
    input  logic                    slow_clk,
    input  logic                    slow_rst,
    input  logic [N_WORDS*DW-1:0]   slow_live,
    output logic [N_WORDS*DW-1:0]   slow_regs,
    output logic                    slow_upd
);
    logic                     req_tgl;
    logic                     rreq_tgl;
    logic                     ack_tgl;
    logic                     rack_tgl;
    logic [N_WORDS*DW-1:0]    hold_flat;
    logic [N_WORDS-1:0]       hold_mask;
    logic [N_WORDS*DW-1:0]    cap_flat;

    shsync_bus_side #(.N_WORDS(N_WORDS), .DW(DW), .STAGES(STAGES)) u_bus (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .ack_tgl(ack_tgl), .rack_tgl(rack_tgl), .cap_flat(cap_flat),
        .req_tgl(req_tgl), .rreq_tgl(rreq_tgl),
        .hold_flat(hold_flat), .hold_mask(hold_mask)
    );

    shsync_slow_side #(.N_WORDS(N_WORDS), .DW(DW), .STAGES(STAGES)) u_slow (
        .slow_clk(slow_clk), .slow_rst(slow_rst),
        .req_tgl(req_tgl), .rreq_tgl(rreq_tgl),
        .hold_flat(hold_flat), .hold_mask(hold_mask),
        .slow_live(slow_live), .slow_regs(slow_regs), .slow_upd(slow_upd),
        .ack_tgl(ack_tgl), .rack_tgl(rack_tgl), .cap_flat(cap_flat)
    );

endmodule

// File: tb/test_shadow_sync_bridge.sv
module test_shadow_sync_bridge;
    import shsync_pkg::*;

    localparam int unsigned N  = 4;
    localparam int unsigned DW = 32;

    logic            clk = 1'b0;
    logic            slow_clk = 1'b0;
    logic            rst = 1'b1;
    logic            slow_rst = 1'b1;
    logic            wr_en = 1'b0;
    logic [7:0]      wr_addr = '0;
    logic [DW-1:0]   wr_data = '0;
    logic [7:0]      rd_addr = '0;
    logic [DW-1:0]   rd_data;
    logic [N*DW-1:0] slow_live = '0;
    logic [N*DW-1:0] slow_regs;
    logic            slow_upd;

    logic [N*DW-1:0] exp_q[$];
    logic [N*DW-1:0] model = '0;
    int compared = 0;
    int mismatched = 0;

    always #4 clk = ~clk;
    always #40 slow_clk = ~slow_clk;

    shadow_sync_bridge #(.N_WORDS(N), .DW(DW)) i_shadow_sync_bridge (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .slow_clk(slow_clk), .slow_rst(slow_rst),
        .slow_live(slow_live), .slow_regs(slow_regs), .slow_upd(slow_upd)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chkw(input string req, input logic [N*DW-1:0] act, input logic [N*DW-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic expect_word(input int idx, input logic [DW-1:0] v);
        model[idx*DW +: DW] = v;
        exp_q.push_back(model);
    endtask

    task automatic wait_idle(input string req);
        logic [DW-1:0] v;
        v = '1;
        for (int k = 0; k < 4000; k++) begin
            bus_rd(PEND_OFFSET, v);
            if (v == '0) break;
        end
        chk(req, v, '0);
        repeat (4) @(negedge slow_clk);
    endtask

    // Scoreboard monitor: every delivery must match the oldest expected image (R6, R7, R8)
    always @(negedge slow_clk) begin
        if (!slow_rst && slow_upd) begin
            compared++;
            if (exp_q.size() == 0) begin
                mismatched++;
                $display("FAIL R6 unexpected delivery: actual %h expected none", slow_regs);
            end else begin
                logic [N*DW-1:0] e;
                e = exp_q.pop_front();
                if (slow_regs !== e) begin
                    mismatched++;
                    $display("FAIL R7/R8 delivery: actual %h expected %h", slow_regs, e);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        logic [N*DW-1:0] live1;
        logic [N*DW-1:0] live2;
        repeat (3) @(posedge slow_clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge slow_clk);
        slow_rst = 1'b0;

        // R1 reset state
        bus_rd(PEND_OFFSET, v); chk("R1 pend", v, '0);
        bus_rd(CTRL_OFFSET, v); chk("R1 ctrl", v, '0);
        bus_rd(8'h00, v);       chk("R1 word0", v, '0);
        chkw("R1 slow_regs", slow_regs, '0);
        chk("R1 slow_upd", {31'd0, slow_upd}, '0);

        // R4 disabled: writes held, R2 readback, R5 pending bit 0
        bus_wr(8'h08, 32'hAAAA_0001);
        bus_rd(8'h08, v);       chk("R2 word2 readback", v, 32'hAAAA_0001);
        bus_rd(PEND_OFFSET, v); chk("R5 write pending", v, 32'h1);
        repeat (20) @(negedge slow_clk);
        bus_rd(PEND_OFFSET, v); chk("R4 still pending", v, 32'h1);
        chkw("R4 slow_regs untouched", slow_regs, '0);
        // R8 coalesce: second value while disabled, one delivery
        bus_wr(8'h08, 32'hBBBB_0002);
        expect_word(2, 32'hBBBB_0002);
        // R3 enable bit, other bits read zero
        bus_wr(CTRL_OFFSET, 32'hFFFF_FFFF);
        bus_rd(CTRL_OFFSET, v); chk("R3 ctrl readback", v, 32'h0020_0000);
        wait_idle("R5 idle after delivery");
        chkw("R8 coalesced value", slow_regs, model);

        // R7 single-word deliveries
        expect_word(0, 32'h1234_5678);
        bus_wr(8'h00, 32'h1234_5678);
        wait_idle("R5 idle word0");
        expect_word(3, 32'hCAFE_0003);
        bus_wr(8'h0C, 32'hCAFE_0003);
        wait_idle("R5 idle word3");
        chkw("R7 only written words", slow_regs, model);

        // R8 write while in flight: two deliveries, latest last
        expect_word(1, 32'hE000_000E);
        bus_wr(8'h04, 32'hE000_000E);
        expect_word(1, 32'hF000_000F);
        bus_wr(8'h04, 32'hF000_000F);
        wait_idle("R8 idle after double write");
        chk("R8 queue drained", 32'(exp_q.size()), 0);

        // R9 reload
        live1 = {32'h4444_0004, 32'h3333_0003, 32'h2222_0002, 32'h1111_0001};
        slow_live = live1;
        bus_wr(PEND_OFFSET, 32'h7FFF_FFFF);
        bus_rd(PEND_OFFSET, v); chk("R9 no reload without bit31", v, '0);
        bus_rd(8'h00, v);       chk("R9 word0 unchanged", v, 32'h1234_5678);
        bus_wr(PEND_OFFSET, 32'h8000_0000);
        bus_rd(PEND_OFFSET, v); chk("R5 reload pending", v, 32'h2);
        wait_idle("R9 reload idle");
        for (int i = 0; i < N; i++) begin
            bus_rd(8'(4 * i), v);
            chk("R9 reloaded word", v, live1[i*DW +: DW]);
        end
        chkw("R9 slow_regs unchanged", slow_regs, model);

        // R10 reload skips a word with an undelivered write
        live2 = {32'h8888_0008, 32'h7777_0007, 32'h6666_0006, 32'h5555_0005};
        slow_live = live2;
        bus_wr(CTRL_OFFSET, 32'h0);
        expect_word(1, 32'h0BAD_F00D);
        bus_wr(8'h04, 32'h0BAD_F00D);
        bus_wr(PEND_OFFSET, 32'h8000_0000);
        bus_rd(PEND_OFFSET, v); chk("R5 both pending", v, 32'h3);
        bus_wr(CTRL_OFFSET, 32'h0020_0000);
        wait_idle("R10 idle");
        bus_rd(8'h04, v); chk("R10 dirty word kept", v, 32'h0BAD_F00D);
        bus_rd(8'h00, v); chk("R10 word0 reloaded", v, live2[0 +: DW]);
        bus_rd(8'h08, v); chk("R10 word2 reloaded", v, live2[2*DW +: DW]);
        bus_rd(8'h0C, v); chk("R10 word3 reloaded", v, live2[3*DW +: DW]);

        // R11 unmapped and misaligned addresses
        bus_wr(8'h20, 32'hDEAD_BEEF);
        bus_wr(8'h01, 32'hDEAD_BEEF);
        bus_rd(PEND_OFFSET, v); chk("R11 no pending", v, '0);
        bus_rd(8'h20, v);       chk("R11 unmapped read", v, '0);
        bus_rd(8'h01, v);       chk("R11 misaligned read", v, '0);
        bus_rd(8'h00, v);       chk("R11 word0 intact", v, live2[0 +: DW]);
        bus_rd(CTRL_OFFSET, v); chk("R11 ctrl intact", v, 32'h0020_0000);
        repeat (10) @(negedge slow_clk);
        chkw("R11 slow_regs intact", slow_regs, model);
        chk("R6 no leftover deliveries", 32'(exp_q.size()), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule